// File: doc/BRIEF.md
# Monitor Sense Sequencer

This block identifies an attached monitor by probing three open-drain ID lines, called A, B and C. When it receives a start strobe, it runs a fixed five-step probe. First it pulls all three lines high for a short precharge interval. Next it lets them float and reads their resting levels. Then it pulls A, B and C low, one at a time, and reads the two lines it is not pulling.

Each step lasts a programmable number of clock cycles, so the pads and the cable can settle before the step is sampled. The samples are packed into an 11-bit sense code. That code is published together with a one-cycle completion pulse. Turning the code into a display mode is done elsewhere.

Line indices are fixed on every 3-bit port: bit 0 is line A, bit 1 is line B and bit 2 is line C. A pad is driven only where its enable bit is 1. Otherwise it floats and the external pull-ups set its level.

Top module: `mon_sense_seq`

## Requirements
- R1: While reset is asserted and after it is released, `drv_en`, `drv_val`, `done` and `code` are all zero.
- R2: A start accepted at a clock edge begins the precharge step at once. The step lasts SHORT_WAIT cycles, with `drv_en` = 3'b111 and `drv_val` = 3'b111.
- R3: The float step follows for LONG_WAIT cycles with `drv_en` = 3'b000 and `drv_val` = 3'b000. Its last cycle samples A into code bit 10, B into bit 9 and C into bit 8.
- R4: The A-low step follows for LONG_WAIT cycles with `drv_en` = 3'b001 and `drv_val` = 3'b000. Its last cycle samples B into code bit 5 and C into bit 4.
- R5: The B-low step follows for LONG_WAIT cycles with `drv_en` = 3'b010 and `drv_val` = 3'b000. Its last cycle samples A into code bit 3 and C into bit 2.
- R6: The C-low step follows for LONG_WAIT cycles with `drv_en` = 3'b100 and `drv_val` = 3'b000. Its last cycle samples A into code bit 1 and B into bit 0.
- R7: Code bits 7 and 6 are always zero.
- R8: In the cycle after the last C-low cycle, `done` is 1 for exactly one cycle and all drivers are off. In that same cycle `code` takes the new value, and it holds that value until the next `done`.
- R9: A start strobe that arrives while a probe is running has no effect on the drive outputs or on when the probe completes.
- R10: A start strobe that is high during the `done` cycle is accepted, and a new probe begins at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a probe when the block is idle |
| line_in | input | 3 | Pad input levels of lines C, B, A (bit 0 = A) |
| drv_val | output | 3 | Level to drive on each line |
| drv_en | output | 3 | Output enable for each line |
| done | output | 1 | One-cycle pulse when a new code is published |
| code | output | 11 | Last completed sense code |

## Verification
The assertions assume `start` is a synchronous level sampled only at clock edges. They also assume `line_in` reaches its final value within the settle window, so that the code depends only on the levels at each step's last cycle. The bench meets both assumptions. Its pad model derives `line_in` combinationally from the drive outputs and a fixed cable configuration. It changes that configuration only while the block is idle, and it drives `start` only at falling edges.

// File: rtl/mon_sense_seq.sv
module mon_sense_seq #(
  parameter int SHORT_WAIT = 200,
  parameter int LONG_WAIT  = 2000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [2:0]  line_in,
  output logic [2:0]  drv_val,
  output logic [2:0]  drv_en,
  output logic        done,
  output logic [10:0] code
);
  localparam int MAXW = (SHORT_WAIT > LONG_WAIT) ? SHORT_WAIT : LONG_WAIT;
  localparam int CW   = $clog2(MAXW + 1);

  typedef enum logic [2:0] {IDLE, PRECHG, FLOAT, LOW_A, LOW_B, LOW_C} st_t;

  st_t          st;
  logic [CW-1:0] cnt;
  logic [10:0]  work;
  logic [10:0]  code_q;
  logic         done_q;
  logic         last;

  assign last = (st == PRECHG) ? (cnt == CW'(SHORT_WAIT - 1))
                               : (cnt == CW'(LONG_WAIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= IDLE;
      cnt    <= '0;
      work   <= '0;
      code_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (st == IDLE) begin
        if (start) begin
          st   <= PRECHG;
          cnt  <= '0;
          work <= '0;
        end
      end else if (!last) begin
        cnt <= cnt + 1'b1;
      end else begin
        cnt <= '0;
        case (st)
          PRECHG: st <= FLOAT;
          FLOAT: begin
            work[10:8] <= {line_in[0], line_in[1], line_in[2]};
            st <= LOW_A;
          end
          LOW_A: begin
            work[5:4] <= {line_in[1], line_in[2]};
            st <= LOW_B;
          end
          LOW_B: begin
            work[3:2] <= {line_in[0], line_in[2]};
            st <= LOW_C;
          end
          default: begin
            code_q <= {work[10:2], line_in[0], line_in[1]};
            done_q <= 1'b1;
            st     <= IDLE;
          end
        endcase
      end
    end
  end

  always_comb begin
    case (st)
      PRECHG:  drv_en = 3'b111;
      LOW_A:   drv_en = 3'b001;
      LOW_B:   drv_en = 3'b010;
      LOW_C:   drv_en = 3'b100;
      default: drv_en = 3'b000;
    endcase
  end

  assign drv_val = (st == PRECHG) ? 3'b111 : 3'b000;
  assign done    = done_q;
  assign code    = code_q;

  a_r2_high_only_all: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_val != 3'b000) |-> (drv_en == 3'b111));
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_done_released: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (drv_en == 3'b000));
  a_r8_code_moves_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    (code != $past(code)) |-> done);
  a_r7_zero_gap: assert property (@(posedge clk) disable iff (!rst_n)
    code[7:6] == 2'b00);
  a_r9_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
    (st != IDLE && start) |=> !(st == PRECHG && cnt == '0));
  a_r4_single_low: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_en != 3'b111) |-> $onehot0(drv_en));
endmodule

// File: tb/sim_mon_sense_seq.sv
module sim_mon_sense_seq;
  localparam int SW = 3;
  localparam int LW = 6;
  localparam int TOTAL = SW + 4 * LW;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  line_in;
  logic [2:0]  drv_val, drv_en;
  logic        done;
  logic [10:0] code;

  logic [2:0]  idle_lv = 3'b111;
  logic [8:0]  link = 9'b0;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit mb = 0;
  int mt = 0;
  bit exp_done = 0;
  logic [10:0] exp_code = '0;

  always #4 clk = ~clk;

  mon_sense_seq #(.SHORT_WAIT(SW), .LONG_WAIT(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .line_in(line_in),
    .drv_val(drv_val), .drv_en(drv_en), .done(done), .code(code));

  always_comb begin
    for (int j = 0; j < 3; j++) begin
      logic pulled;
      pulled = 1'b0;
      for (int i = 0; i < 3; i++)
        if (drv_en[i] && !drv_val[i] && link[3*i+j]) pulled = 1'b1;
      line_in[j] = drv_en[j] ? drv_val[j] : (idle_lv[j] & ~pulled);
    end
  end

  function automatic logic [10:0] calc(input logic [2:0] lv, input logic [8:0] lk);
    logic [10:0] c;
    c = '0;
    c[10] = lv[0]; c[9] = lv[1]; c[8] = lv[2];
    c[5] = lv[1] & ~lk[1];  c[4] = lv[2] & ~lk[2];
    c[3] = lv[0] & ~lk[3];  c[2] = lv[2] & ~lk[5];
    c[1] = lv[0] & ~lk[6];  c[0] = lv[1] & ~lk[7];
    return c;
  endfunction

  always @(posedge clk) begin
    cyc++;
    exp_done = 0;
    if (!rst_n) begin
      mb = 0; mt = 0; exp_code = '0;
    end else if (!mb) begin
      if (start) begin mb = 1; mt = 0; end
    end else begin
      mt++;
      if (mt == TOTAL) begin
        mb = 0; exp_done = 1; exp_code = calc(idle_lv, link);
      end
    end
  end

  always @(negedge clk) begin
    logic [2:0] ee, ev;
    int p;
    p = (mt < SW) ? 0 : 1 + (mt - SW) / LW;
    ee = 3'b000; ev = 3'b000;
    if (mb) begin
      case (p)
        0: begin ee = 3'b111; ev = 3'b111; end
        2: ee = 3'b001;
        3: ee = 3'b010;
        4: ee = 3'b100;
        default: ee = 3'b000;
      endcase
    end
    n_cmp++;
    if (drv_en !== ee || drv_val !== ev || done !== exp_done || code !== exp_code) begin
      string tag;
      n_bad++;
      if (!rst_n) tag = "R1";
      else if (done !== exp_done) tag = "R8";
      else if (code[10:8] !== exp_code[10:8]) tag = "R3";
      else if (code[7:6] !== exp_code[7:6]) tag = "R7";
      else if (code[5:4] !== exp_code[5:4]) tag = "R4";
      else if (code[3:2] !== exp_code[3:2]) tag = "R5";
      else if (code[1:0] !== exp_code[1:0]) tag = "R6";
      else if (!mb) tag = "R9";
      else if (p == 0) tag = "R2";
      else tag = (p == 1) ? "R3" : (p == 2) ? "R4" : (p == 3) ? "R5" : "R6";
      $display("FAIL %s cyc %0d: en=%b val=%b done=%b code=%b expected en=%b val=%b done=%b code=%b",
               tag, cyc, drv_en, drv_val, done, code, ee, ev, exp_done, exp_code);
    end
  end

  always @(posedge clk) begin
    if (cyc > 20000) begin
      n_bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic probe(input logic [2:0] lv, input logic [8:0] lk);
    @(negedge clk);
    idle_lv = lv; link = lk;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (TOTAL + 2) @(negedge clk);
  endtask

  initial begin
    // R1: reset state compared each cycle while held
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R2 R3 R4 R5 R6 R7: several cable patterns
    probe(3'b111, 9'b0);
    probe(3'b101, 9'b0);
    probe(3'b111, 9'b010_001_110);
    probe(3'b011, 9'b101_101_101);
    probe(3'b110, 9'b011_100_010);
    // R9: start pulses during a running probe
    @(negedge clk);
    idle_lv = 3'b111; link = 9'b100_000_010;
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (SW + 1) @(negedge clk);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (2 * LW) @(negedge clk);
    start = 1'b1;
    repeat (3) @(negedge clk);
    start = 1'b0;
    wait (done === 1'b1);
    // R10: start held during the done cycle starts a new probe
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (TOTAL + 3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule